// File: doc/BRIEF.md
# T1 Transmit Channel Idle and Signaling Multiplexer

This block sits on the transmit side of a T1 line interface. It takes serial PCM bits from a system highway and rebuilds the 24 channel bytes that go toward the line. The highway frame has 32 time-slots of 8 bits each. Every fourth slot carries no T1 channel and is dropped. Each of the remaining 24 slots becomes one output byte, tagged with its channel index.

Each channel byte can then be changed in one of two ways. If the channel is flagged in the idle mask, the byte is replaced by a programmable idle code. In frames that carry signaling, the least significant bit can be replaced by a per-channel signaling bit, unless the channel is flagged as clear-channel. A clear-channel byte passes through unchanged.

A frame sync pulse sets the bit position. It reloads the slot counter and the bit counter with programmable offsets. When no pulse arrives, the counters wrap on their own at the end of the frame. The highway runs at one of two rates: one bit per clock, or one bit every two clocks.

Top module: `t1_tx_mux`

## Requirements
- R1: While `rst_ni` is low, and until the first byte after reset, `byte_vld_o` is 0, `byte_o` is 0x00 and `chan_o` is 0.
- R2: With `rate_4m_i`=0, one highway bit is sampled on every clock. Frame bit position p (0 to 255) belongs to slot p/8, and the bits of a slot arrive MSB first, so the bit at p%8=0 is byte bit 7.
- R3: With `rate_4m_i`=1, each highway bit lasts two clocks and is sampled in the first of the two. A sync pulse always starts a fresh two-clock bit.
- R4: A slot s with s%4=0 is unequipped and never produces a strobe. An equipped slot s produces a byte on channel s - s/4 - 1, which ranges from 0 to 23. A free-running frame therefore gives exactly 24 strobes.
- R5: `byte_vld_o` goes high for exactly one clock, on the clock after the sample of a slot's last bit. `byte_o` and `chan_o` are valid in that same clock.
- R6: In a cycle where `sync_i`=1, the bit sampled in that cycle is taken as slot `slot_ofs_i`, bit `bit_ofs_i` (bit 0 is the MSB), and counting continues from that point.
- R7: If no sync pulse arrives, the position after slot 31 bit 7 is slot 0 bit 0.
- R8: If bit c of `idle_mask_i` is set in the last-bit sample cycle, the byte for channel c is `idle_code_i`.
- R9: If `sig_frame_i`=1 in the last-bit sample cycle, and channel c is neither idle nor clear, then byte bit 0 is `sig_bits_i[c]` and bits 7:1 are the highway data.
- R10: If bit c of `clear_mask_i` is set and the channel is not idle, the byte is the highway data unchanged, whatever the values of `sig_frame_i` and `sig_bits_i`.
- R11: The idle overwrite takes priority over signaling insertion.
- R12: `byte_o` and `chan_o` keep their values in every clock where `byte_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync pulse; reloads the position counters |
| ser_i | input | 1 | Serial highway data |
| rate_4m_i | input | 1 | 1 selects two clocks per bit |
| slot_ofs_i | input | 5 | Slot loaded on sync |
| bit_ofs_i | input | 3 | Bit loaded on sync (0 is the MSB) |
| idle_mask_i | input | 24 | Per-channel idle overwrite enable |
| idle_code_i | input | 8 | Idle code byte |
| clear_mask_i | input | 24 | Per-channel clear-channel flag |
| sig_frame_i | input | 1 | The current frame carries signaling |
| sig_bits_i | input | 24 | Per-channel signaling bit |
| byte_vld_o | output | 1 | One-clock strobe for an output byte |
| byte_o | output | 8 | Channel byte |
| chan_o | output | 5 | Channel index, 0 to 23 |

## Verification
On every cycle, the assertions check that the strobe lasts one clock, that the channel index stays in range, and that the outputs hold between strobes. They also check the idle-code priority and the placement of the signaling bit against the control inputs registered in the strobe cycle.

Only the bench's scenarios can show that:
- the right slots are dropped,
- bytes assemble MSB first at both rates,
- sync offsets land on the right bit,
- the frame wraps.

The bench does this by comparing against a reference model that tracks one integer frame position.

// File: rtl/t1_tx_pkg.sv
package t1_tx_pkg;
  localparam int SLOTS  = 32;
  localparam int BITS   = 8;
  localparam int CHANS  = 24;
  localparam int GROUP  = 4;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BIT_W  = $clog2(BITS);
  localparam int CHAN_W = $clog2(CHANS);

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [BIT_W-1:0]  bitpos_t;
  typedef logic [CHAN_W-1:0] chan_t;
  typedef logic [BITS-1:0]   byte_t;

  function automatic logic slot_equipped(slot_t s);
    return (int'(s) % GROUP) != 0;
  endfunction

  function automatic chan_t slot_to_chan(slot_t s);
    return chan_t'(int'(s) - int'(s) / GROUP - 1);
  endfunction
endpackage

// File: rtl/t1_tx_timebase.sv
module t1_tx_timebase
  import t1_tx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sync_i,
  input  logic    rate_4m_i,
  input  slot_t   slot_ofs_i,
  input  bitpos_t bit_ofs_i,
  output slot_t   slot_o,
  output bitpos_t bit_o,
  output logic    sample_o
);
  slot_t   slot_q, slot_d;
  bitpos_t bit_q, bit_d;
  logic    ph_q, ph_d, ph_c;

  // position in effect this cycle; sync overrides the running counters
  always_comb begin
    slot_o   = sync_i ? slot_ofs_i : slot_q;
    bit_o    = sync_i ? bit_ofs_i  : bit_q;
    ph_c     = sync_i ? 1'b0       : ph_q;
    sample_o = !ph_c;
  end

  always_comb begin
    slot_d = slot_o;
    bit_d  = bit_o;
    ph_d   = 1'b0;
    if (rate_4m_i && !ph_c) begin
      ph_d = 1'b1;
    end else if (bit_o == bitpos_t'(BITS-1)) begin
      bit_d  = '0;
      slot_d = (slot_o == slot_t'(SLOTS-1)) ? '0 : slot_o + 1'b1;
    end else begin
      bit_d = bit_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      bit_q  <= '0;
      ph_q   <= 1'b0;
    end else begin
      slot_q <= slot_d;
      bit_q  <= bit_d;
      ph_q   <= ph_d;
    end
  end
endmodule

// File: rtl/t1_tx_deser.sv
module t1_tx_deser
  import t1_tx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sample_i,
  input  logic  ser_i,
  output byte_t byte_o
);
  byte_t acc_q;

  // includes the bit being sampled now
  assign byte_o = {acc_q[BITS-2:0], ser_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (sample_i) acc_q <= byte_o;
  end
endmodule

// File: rtl/t1_tx_byte_sel.sv
module t1_tx_byte_sel
  import t1_tx_pkg::*;
(
  input  byte_t             raw_i,
  input  chan_t             chan_i,
  input  logic [CHANS-1:0]  idle_mask_i,
  input  byte_t             idle_code_i,
  input  logic [CHANS-1:0]  clear_mask_i,
  input  logic              sig_frame_i,
  input  logic [CHANS-1:0]  sig_bits_i,
  output byte_t             byte_o
);
  logic idle_c, clear_c, sig_c;

  always_comb begin
    idle_c  = idle_mask_i[chan_i];
    clear_c = clear_mask_i[chan_i];
    sig_c   = sig_bits_i[chan_i];
    if (idle_c)
      byte_o = idle_code_i;
    else if (sig_frame_i && !clear_c)
      byte_o = {raw_i[BITS-1:1], sig_c};
    else
      byte_o = raw_i;
  end
endmodule

// File: rtl/t1_tx_mux.sv
module t1_tx_mux
  import t1_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              ser_i,
  input  logic              rate_4m_i,
  input  logic [SLOT_W-1:0] slot_ofs_i,
  input  logic [BIT_W-1:0]  bit_ofs_i,
  input  logic [CHANS-1:0]  idle_mask_i,
  input  logic [BITS-1:0]   idle_code_i,
  input  logic [CHANS-1:0]  clear_mask_i,
  input  logic              sig_frame_i,
  input  logic [CHANS-1:0]  sig_bits_i,
  output logic              byte_vld_o,
  output logic [BITS-1:0]   byte_o,
  output logic [CHAN_W-1:0] chan_o
);
  slot_t   slot_c;
  bitpos_t bit_c;
  logic    sample_c, emit_c;
  byte_t   raw_c, sel_c;
  chan_t   chan_c;

  t1_tx_timebase u_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .rate_4m_i  (rate_4m_i),
    .slot_ofs_i (slot_ofs_i),
    .bit_ofs_i  (bit_ofs_i),
    .slot_o     (slot_c),
    .bit_o      (bit_c),
    .sample_o   (sample_c)
  );

  t1_tx_deser u_deser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_c),
    .ser_i    (ser_i),
    .byte_o   (raw_c)
  );

  assign chan_c = slot_to_chan(slot_c);
  assign emit_c = sample_c && (bit_c == bitpos_t'(BITS-1)) && slot_equipped(slot_c);

  t1_tx_byte_sel u_sel (
    .raw_i        (raw_c),
    .chan_i       (chan_c),
    .idle_mask_i  (idle_mask_i),
    .idle_code_i  (idle_code_i),
    .clear_mask_i (clear_mask_i),
    .sig_frame_i  (sig_frame_i),
    .sig_bits_i   (sig_bits_i),
    .byte_o       (sel_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      chan_o     <= '0;
    end else begin
      byte_vld_o <= emit_c;
      if (emit_c) begin
        byte_o <= sel_c;
        chan_o <= chan_c;
      end
    end
  end
endmodule

// File: rtl/t1_tx_mux_chk.sv
module t1_tx_mux_chk
  import t1_tx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_i,
  input logic              ser_i,
  input logic              rate_4m_i,
  input logic [SLOT_W-1:0] slot_ofs_i,
  input logic [BIT_W-1:0]  bit_ofs_i,
  input logic [CHANS-1:0]  idle_mask_i,
  input logic [BITS-1:0]   idle_code_i,
  input logic [CHANS-1:0]  clear_mask_i,
  input logic              sig_frame_i,
  input logic [CHANS-1:0]  sig_bits_i,
  input logic              byte_vld_o,
  input logic [BITS-1:0]   byte_o,
  input logic [CHAN_W-1:0] chan_o
);
  logic [CHANS-1:0] idle_q, clear_q, sig_q;
  logic [BITS-1:0]  code_q;
  logic             sigf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q  <= '0;
      clear_q <= '0;
      sig_q   <= '0;
      code_q  <= '0;
      sigf_q  <= 1'b0;
    end else begin
      idle_q  <= idle_mask_i;
      clear_q <= clear_mask_i;
      sig_q   <= sig_bits_i;
      code_q  <= idle_code_i;
      sigf_q  <= sig_frame_i;
    end
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);  // R5
  AST_CHAN_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> int'(chan_o) < CHANS);  // R4
  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> ($stable(byte_o) && $stable(chan_o)));  // R12
  AST_IDLE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && idle_q[chan_o]) |-> byte_o == code_q);  // R11
  AST_SIG_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && !idle_q[chan_o] && sigf_q && !clear_q[chan_o]) |-> byte_o[0] == sig_q[chan_o]);  // R9
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!byte_vld_o && byte_o == '0 && chan_o == '0));  // R1
endmodule

bind t1_tx_mux t1_tx_mux_chk u_chk (.*);

// File: tb/t1_tx_mux_bench.sv
module t1_tx_mux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0, ser = 1'b0, rate4 = 1'b0, sigf = 1'b0;
  logic [4:0]  slot_ofs = '0;
  logic [2:0]  bit_ofs = '0;
  logic [23:0] idle_m = '0, clear_m = '0, sig_b = '0;
  logic [7:0]  code = 8'h00;
  logic        vld;
  logic [7:0]  dout;
  logic [4:0]  chan;

  int checks = 0, errors = 0, vld_cnt = 0, cyc = 0;
  string tag = "R1";
  bit done = 0;

  logic       e_vld = 0;
  logic [7:0] e_byte = 0, acc = 0;
  logic [4:0] e_chan = 0;
  int pos = 0, ph = 0;

  always #2 clk = ~clk;

  t1_tx_mux u_t1_tx_mux (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .ser_i(ser), .rate_4m_i(rate4),
    .slot_ofs_i(slot_ofs), .bit_ofs_i(bit_ofs), .idle_mask_i(idle_m),
    .idle_code_i(code), .clear_mask_i(clear_m), .sig_frame_i(sigf),
    .sig_bits_i(sig_b), .byte_vld_o(vld), .byte_o(dout), .chan_o(chan)
  );

  // reference model: single integer frame position 0..255
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = 0; ph = 0; acc = 0; e_vld = 0; e_byte = 0; e_chan = 0;
    end else begin
      int p, h, s, c;
      p = sync ? (int'(slot_ofs) * 8 + int'(bit_ofs)) : pos;
      h = sync ? 0 : ph;
      e_vld = 0;
      if (h == 0) begin
        acc = {acc[6:0], ser};
        s = p / 8;
        if (p % 8 == 7 && s % 4 != 0) begin
          c = s - s / 4 - 1;
          e_vld = 1;
          e_chan = 5'(c);
          if (idle_m[c]) e_byte = code;
          else if (sigf && !clear_m[c]) e_byte = {acc[7:1], sig_b[c]};
          else e_byte = acc;
        end
      end
      if (rate4 && h == 0) begin ph = 1; pos = p; end
      else begin ph = 0; pos = (p + 1) % 256; end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (vld) vld_cnt++;
    if (rst_n && !done) begin
      checks++;
      if (vld !== e_vld || chan !== e_chan || dout !== e_byte) begin
        errors++;
        $display("FAIL %s vld/chan/byte act %b/%0d/%h exp %b/%0d/%h",
                 tag, vld, chan, dout, e_vld, e_chan, e_byte);
      end
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync = 1'b0;
      ser = 1'($urandom);
    end
  endtask

  task automatic pulse_sync(logic [4:0] so, logic [2:0] bo);
    @(negedge clk);
    slot_ofs = so; bit_ofs = bo; sync = 1'b1; ser = 1'($urandom);
  endtask

  task automatic count_check(string t, int n, int exp);
    int start;
    start = vld_cnt;
    run(n);
    checks++;
    if (vld_cnt - start != exp) begin
      errors++;
      $display("FAIL %s strobes act %0d exp %0d", t, vld_cnt - start, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1
    if (vld !== 0 || dout !== 0 || chan !== 0) begin
      errors++;
      $display("FAIL R1 reset act %b/%h/%0d exp 0/00/0", vld, dout, chan);
    end
    rst_n = 1'b1;
    tag = "R2"; pulse_sync(0, 0); run(300);
    tag = "R7"; count_check("R4 R7", 256, 24);
    tag = "R8"; idle_m = 24'h80_0421; code = 8'h7E; run(300);
    tag = "R9"; idle_m = 0; sigf = 1; sig_b = 24'h5A_A5C3; run(300);
    tag = "R10"; clear_m = 24'hF0_0F0F; run(300);
    tag = "R11"; idle_m = 24'h0C_0301; code = 8'hD5; run(300);
    tag = "R6"; pulse_sync(5, 3); run(200); pulse_sync(31, 6); run(200);
    tag = "R3"; rate4 = 1; pulse_sync(0, 0); run(700);
    tag = "R6"; pulse_sync(9, 2); run(100); pulse_sync(2, 7); run(600);
    tag = "R4"; count_check("R4 R3", 512, 24);
    tag = "R12"; rate4 = 0; idle_m = 0; sigf = 0; run(300);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act %0d exp done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule